// File: doc/BRIEF.md
# Frame-Aligned Serial ADC Deserializer

This block rebuilds parallel samples from the serial lanes of a multi-channel ADC. Each clock cycle it receives, for every data lane and for the frame lane, the two bits captured on the rising and falling edges of the bit clock. The rising-edge bit is the older of the two. The frame lane is handled exactly like a data lane. Its 0-to-1 transition marks the first bit of a sample, and it can fall on either the rising-edge slot or the falling-edge slot of a cycle.

Each lane feeds a short shift history. When the frame lane shows a start edge at the expected position, a single 2:1 multiplexer per lane selects the bits that end just before that edge, and the complete word is registered together with a one-cycle valid strobe. The edge position is tracked at half-cycle resolution, so configurations with an odd number of bits per lane per sample, such as 7 bits on one lane, work without a second clock. Lane count and serialization factor are parameters. The supported sets are one or two lanes and 6, 7, 8, 12, 14 or 16 bits, with the width divisible by the lane count.

Top module: `frame_deser`

## Requirements
- R1: A synchronous reset clears the parallel output to zero and holds the valid strobe and the aligned flag low.
- R2: With two lanes, lane 1 carries odd sample bits and lane 0 carries even sample bits. In time slot t of a sample (slot 0 first, rising-edge bit before falling-edge bit), lane l holds sample bit `LANE_COUNT*(BITS_PER_LANE-1-t)+l`, so the most significant bit arrives first.
- R3: The frame lane is high for the first ceil(BITS_PER_LANE/2) slots of each sample and low for the rest. The slot where it goes from 0 to 1 is the first slot of a sample, and this holds whether that slot is a rising-edge or a falling-edge bit. Each output word is made of exactly the bits between two consecutive start edges, so it never mixes bits from two samples.
- R4: After reset, or after a misplaced edge, no word is output until a start edge arrives exactly one sample period after the previous one. That edge produces the first word and raises the aligned flag.
- R5: When the clock cycle whose inputs carry a start edge is consistent with the tracked alignment, the valid strobe goes high for exactly one cycle after that clock edge, and the word of the sample that just ended appears with it. Valid pulses therefore occur at the ADC sample rate.
- R6: A start edge at an unexpected slot clears the aligned flag and produces no word. The block then re-locks at the new position, and the next consistent edge produces a word again.
- R7: Between valid pulses the parallel output holds the last word.
- R8: With one lane and an odd number of bits per sample (7), start edges alternate between rising and falling slots, and every sample is still recovered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-clock-domain clock, one cycle per bit pair |
| rst | input | 1 | Synchronous reset, active high |
| laneRise | input | LANE_COUNT | Data bits captured on the rising bit-clock edge (older bit) |
| laneFall | input | LANE_COUNT | Data bits captured on the falling bit-clock edge (newer bit) |
| frameRise | input | 1 | Frame lane bit captured on the rising edge |
| frameFall | input | 1 | Frame lane bit captured on the falling edge |
| sampleOut | output | SAMPLE_WIDTH | Last recovered parallel sample |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |
| aligned | output | 1 | High while the frame edge is at the tracked position |

## Verification
The bench builds two instances at once. One uses two lanes and 12 bits, so each sample spans three whole cycles. The other uses one lane and 7 bits, where a sample spans three and a half cycles and the start edge alternates between the rising and falling slots. Every stream starting offset within a sample period is swept for both builds. The 7-bit build receives all 128 sample values, and the 12-bit build receives walking ones plus arithmetic patterns, which exposes any bit swap or sample split. Streams with one inserted slot in mid-flight exercise loss of alignment and re-locking, and every cycle's valid, aligned and held output is compared with values computed from the slot arithmetic.

// File: rtl/frame_deser_pkg.sv
`timescale 1ns/1ps
package frame_deser_pkg;
  // strobes from the alignment tracker to the lane datapath
  typedef struct packed {
    logic load;       // capture a complete word this cycle
    logic phaseLate;  // word ends on this cycle's rising-edge bit
  } deserStrobe_t;
endpackage

// File: rtl/frame_deser_align.sv
`timescale 1ns/1ps
module frame_deser_align
  import frame_deser_pkg::*;
#(
  parameter int BITS_PER_LANE = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frameRise,
  input  logic         frameFall,
  output deserStrobe_t strobe,
  output logic         aligned
);
  localparam int PW = $clog2(BITS_PER_LANE);
  localparam int LAST_I = BITS_PER_LANE - 1;
  localparam logic [PW:0] BPL_W = BITS_PER_LANE[PW:0];
  localparam logic [PW:0] LAST_W = LAST_I[PW:0];
  localparam logic [PW:0] STEP = 2;

  logic prevFallQ, havePosQ, alignedQ;
  logic [PW:0] posQ;           // slot index of the rising-edge bit within its sample
  logic edgeEarly, edgeLate, anyEdge, match;
  logic [PW:0] posSum, predPos, edgePos;

  always_comb begin
    edgeEarly = frameRise & ~prevFallQ;   // 0->1 between previous fall and this rise
    edgeLate  = frameFall & ~frameRise;   // 0->1 between this rise and this fall
    anyEdge   = edgeEarly | edgeLate;
    posSum    = posQ + STEP;
    predPos   = (posSum >= BPL_W) ? posSum - BPL_W : posSum;
    edgePos   = edgeEarly ? '0 : LAST_W;
    match     = havePosQ & anyEdge & (predPos == edgePos);
    strobe.load      = match;
    strobe.phaseLate = match & ~edgeEarly;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevFallQ <= 1'b0;
      havePosQ  <= 1'b0;
      alignedQ  <= 1'b0;
      posQ      <= '0;
    end else begin
      prevFallQ <= frameFall;
      posQ      <= anyEdge ? edgePos : predPos;
      havePosQ  <= havePosQ | anyEdge;
      if (anyEdge) alignedQ <= match;
    end
  end

  assign aligned = alignedQ;

  assert_drop_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(alignedQ) |-> $past(anyEdge));
endmodule

// File: rtl/frame_deser_lanes.sv
`timescale 1ns/1ps
module frame_deser_lanes
  import frame_deser_pkg::*;
#(
  parameter int LANE_COUNT    = 2,
  parameter int BITS_PER_LANE = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANE_COUNT-1:0] laneRise,
  input  logic [LANE_COUNT-1:0] laneFall,
  input  deserStrobe_t          strobe,
  output logic [LANE_COUNT*BITS_PER_LANE-1:0] sampleOut,
  output logic                  sampleValid
);
  localparam int WIDTH = LANE_COUNT * BITS_PER_LANE;

  // newest bit at index 0, oldest at the top
  logic [LANE_COUNT-1:0][BITS_PER_LANE-1:0] histQ;
  logic [LANE_COUNT-1:0][BITS_PER_LANE-1:0] laneWord;
  logic [WIDTH-1:0] assembled;
  logic [WIDTH-1:0] sampleQ;
  logic validQ;

  always_ff @(posedge clk) begin
    if (rst) histQ <= '0;
    else
      for (int l = 0; l < LANE_COUNT; l++)
        histQ[l] <= {histQ[l][BITS_PER_LANE-3:0], laneRise[l], laneFall[l]};
  end

  // one 2:1 mux per bit picks the word end: previous fall or this rise
  always_comb
    for (int l = 0; l < LANE_COUNT; l++)
      laneWord[l] = strobe.phaseLate ? {histQ[l][BITS_PER_LANE-2:0], laneRise[l]}
                                     : histQ[l];

  generate
    for (genvar j = 0; j < BITS_PER_LANE; j++) begin : g_slot
      for (genvar l = 0; l < LANE_COUNT; l++) begin : g_lane
        assign assembled[LANE_COUNT*j+l] = laneWord[l][j];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleQ <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobe.load;
      if (strobe.load) sampleQ <= assembled;
    end
  end

  assign sampleOut   = sampleQ;
  assign sampleValid = validQ;

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
    !validQ |-> $stable(sampleQ));
endmodule

// File: rtl/frame_deser.sv
`timescale 1ns/1ps
module frame_deser
  import frame_deser_pkg::*;
#(
  parameter int LANE_COUNT   = 2,
  parameter int SAMPLE_WIDTH = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANE_COUNT-1:0]   laneRise,
  input  logic [LANE_COUNT-1:0]   laneFall,
  input  logic                    frameRise,
  input  logic                    frameFall,
  output logic [SAMPLE_WIDTH-1:0] sampleOut,
  output logic                    sampleValid,
  output logic                    aligned
);
  localparam int BITS_PER_LANE = SAMPLE_WIDTH / LANE_COUNT;

  deserStrobe_t strobe;

  frame_deser_align #(.BITS_PER_LANE(BITS_PER_LANE)) u_align (
    .clk(clk), .rst(rst), .frameRise(frameRise), .frameFall(frameFall),
    .strobe(strobe), .aligned(aligned)
  );

  frame_deser_lanes #(.LANE_COUNT(LANE_COUNT), .BITS_PER_LANE(BITS_PER_LANE)) u_lanes (
    .clk(clk), .rst(rst), .laneRise(laneRise), .laneFall(laneFall),
    .strobe(strobe), .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  assert_valid_when_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> aligned);
  assert_lock_emits_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> sampleValid);
  assert_valid_after_edge_R5: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> $past(frameRise | frameFall));
endmodule

// File: tb/frame_deser_tb.sv
`timescale 1ns/1ps
module frame_deser_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [1:0] rA, fA;
  logic frRA, frFA, vA, alA;
  logic [11:0] outA;
  logic [0:0] rB, fB;
  logic frRB, frFB, vB, alB;
  logic [6:0] outB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  frame_deser #(.LANE_COUNT(2), .SAMPLE_WIDTH(12)) u_dut (
    .clk(clk), .rst(rst), .laneRise(rA), .laneFall(fA), .frameRise(frRA),
    .frameFall(frFA), .sampleOut(outA), .sampleValid(vA), .aligned(alA));

  frame_deser #(.LANE_COUNT(1), .SAMPLE_WIDTH(7)) u_dut7 (
    .clk(clk), .rst(rst), .laneRise(rB), .laneFall(fB), .frameRise(frRB),
    .frameFall(frFB), .sampleOut(outB), .sampleValid(vB), .aligned(alB));

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sampleVal(int cfg, int k, int seed);
    if (cfg == 1) return (k + seed) & 127;
    if (seed == 0) return 1 << (k % 12);
    return (k * 2731 + seed * 977) & 12'hFFF;
  endfunction

  function automatic int startSlot(int cfg, int off, int gl, int k);
    int bpl = cfg ? 7 : 6;
    return off + k * bpl + ((gl >= 0 && k >= gl) ? 1 : 0);
  endfunction

  // returns {frame, lane1, lane0} for a slot
  function automatic logic [2:0] slotBits(int cfg, int off, int gl, int nSamp, int seed, int s);
    int bpl = cfg ? 7 : 6;
    int lanes = cfg ? 1 : 2;
    int r = s - off;
    int k, t, v;
    logic [2:0] res = '0;
    if (r < 0) return res;
    if (gl >= 0 && r >= gl * bpl) begin
      if (r == gl * bpl) return res;
      r = r - 1;
    end
    k = r / bpl;
    t = r % bpl;
    if (k >= nSamp) return res;
    v = sampleVal(cfg, k, seed);
    res[2] = (t < (bpl + 1) / 2);
    for (int l = 0; l < lanes; l++) res[l] = v[lanes * (bpl - 1 - t) + l];
    return res;
  endfunction

  task automatic runCase(int cfg, int off, int gl, int nSamp, int seed);
    int bpl = cfg ? 7 : 6;
    int nCyc = (off + nSamp * bpl + 3) / 2 + 3;
    int lastOut = 0;
    int expAl = 0;
    logic [2:0] b0, b1;
    string tagV, tagD;
    tagD = cfg ? "R8 one-lane 7-bit word" : "R2/R3 two-lane word";
    rst = 1; rA = 0; fA = 0; frRA = 0; frFA = 0; rB = 0; fB = 0; frRB = 0; frFB = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset valid", cfg ? vB : vA, 0);
    check("R1 reset aligned", cfg ? alB : alA, 0);
    check("R1 reset output", cfg ? outB : outA, 0);
    for (int c = 0; c <= nCyc; c++) begin
      if (c > 0) begin
        int found = -1;
        int expV;
        for (int k = 0; k < nSamp; k++) begin
          int st = startSlot(cfg, off, gl, k);
          if (st == 2 * (c - 1) || st == 2 * (c - 1) + 1) found = k;
        end
        expV = (found >= 1 && found != gl);
        if (found >= 0) expAl = expV;
        tagV = (gl >= 0) ? "R6 valid" : "R5 valid";
        check(tagV, cfg ? vB : vA, expV);
        check((gl >= 0) ? "R6 aligned" : "R4 aligned", cfg ? alB : alA, expAl);
        if (expV) begin
          lastOut = sampleVal(cfg, found - 1, seed);
          check(tagD, cfg ? outB : outA, lastOut);
        end else begin
          check("R7 held output", cfg ? outB : outA, lastOut);
        end
      end
      b0 = slotBits(cfg, off, gl, nSamp, seed, 2 * c);
      b1 = slotBits(cfg, off, gl, nSamp, seed, 2 * c + 1);
      if (cfg == 0) begin
        rA = b0[1:0]; fA = b1[1:0]; frRA = b0[2]; frFA = b1[2];
      end else begin
        rB = b0[0:0]; fB = b1[0:0]; frRB = b0[2]; frFB = b1[2];
      end
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1;
    for (int off = 0; off < 6; off++) runCase(0, off, -1, 20, 0);
    for (int off = 0; off < 4; off++) runCase(0, off, -1, 60, 5 + off);
    for (int off = 0; off < 7; off++) runCase(1, off, -1, 135, off * 11);
    runCase(0, 1, 7, 30, 3);
    runCase(0, 4, 2, 30, 9);
    runCase(1, 2, 9, 40, 17);
    runCase(1, 5, 4, 40, 60);
    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule